// File: doc/BRIEF.md
# Bit-Field ALU with Group-Swap Flip

A purely combinational 32-bit arithmetic and logic unit that sits in the execute stage of a small processor pipeline. A 4-bit operation code picks one of fifteen functions. The first operand comes straight from a register. The second operand comes either from a register or from a 10-bit immediate that is sign-extended. The unit returns the 32-bit result together with a flag that marks the one unused operation code.

Beyond the usual add, subtract, logic, shift and rotate functions, the unit has three bit-field operations and a flip. For the bit-field operations, the field offset and the field width are packed into the second operand, and a width code of zero stands for a 16-bit field. The flip runs five staged swaps of neighbouring bit groups; bits of the second operand enable each stage. The register index for the second operand is driven out combinationally, so the surrounding register file can return that register's value in the same cycle.

There is no clock and no internal state. The outputs settle from the inputs in one combinational pass.

Top module: `bfalu_core`

## Requirements
- R1: When `b_sel[10]` is 1, operand B is `b_sel[9:0]` sign-extended to 32 bits. When it is 0, operand B is `b_reg_data`. In both cases `b_reg_idx` equals `b_sel[4:0]`.
- R2: Code 0 returns A+B and code 2 returns A-B, both modulo 2^32.
- R3: Code 4 returns A AND B, code 5 returns A OR B, code 6 returns A XOR B and code 7 returns NOT(A XOR B).
- R4: Code 1 rotates A right by B[4:0]. Higher bits of B have no effect.
- R5: Code 3 returns (A shifted left by 10) OR B[9:0].
- R6: Code 8 is a logical left shift, code 9 a logical right shift and code A an arithmetic right shift of A. The shift amount is B[4:0].
- R7: Code B (field insert) takes POS = B[4:0] and LEN = B[8:5], where LEN 0 means 16. Bits POS..POS+LEN-1 of A are replaced by the low LEN bits of B>>10. All other bits of A are kept, and field bits above bit 31 are dropped.
- R8: Code D (unsigned extract) returns (A>>POS) masked to LEN bits, with the same POS and LEN as R7, including LEN code 0 meaning 16.
- R9: Code C (signed extract) returns the R8 field sign-extended from its top bit, bit LEN-1.
- R10: Code E (flip) runs stages k = 0..4 in order. When B[k] is 1, stage k swaps each neighbouring pair of 2^k-bit groups. When B[4:0] is 0, the result is A.
- R11: Code F sets `illegal` to 1 and the result to 0. Every other code gives `illegal` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a_val | input | 32 | Operand A |
| b_sel | input | 11 | Bit 10 selects the immediate; bits 9:0 are the immediate or hold the register index in bits 4:0 |
| b_reg_data | input | 32 | Value of the register addressed by `b_reg_idx` |
| b_reg_idx | output | 5 | Register index for operand B |
| result | output | 32 | Operation result |
| illegal | output | 1 | High for operation code F |

## Verification
The checks evaluate `result` and `illegal` in every evaluation of the logic. They rely on all inputs being 2-state and stable, and on `b_reg_data` already being the value for the index currently driven out. The bench meets this by changing every input together, just after a rising clock edge, and by reading the outputs only at the following falling edge. It treats `b_reg_data` as a free input rather than modelling a register file.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;
    parameter int DATA_W   = 32;
    parameter int IMM_W    = 10;
    parameter int IDX_W    = 5;
    parameter int LEN_W    = 4;
    parameter int CAT_SH   = 10;
    parameter int FLD_SRC  = 10;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ROR  = 4'h1,
        OP_SUB  = 4'h2,
        OP_CAT  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_XNOR = 4'h7,
        OP_SHL  = 4'h8,
        OP_SHR  = 4'h9,
        OP_SAR  = 4'hA,
        OP_FINS = 4'hB,
        OP_SEXT = 4'hC,
        OP_UEXT = 4'hD,
        OP_FLIP = 4'hE,
        OP_BAD  = 4'hF
    } alu_op_e;
endpackage

// File: rtl/bfalu_opb_sel.sv
module bfalu_opb_sel #(
    parameter int DATA_W = bfalu_pkg::DATA_W,
    parameter int IMM_W  = bfalu_pkg::IMM_W,
    parameter int IDX_W  = bfalu_pkg::IDX_W
) (
    input  logic [IMM_W:0]    sel,
    input  logic [DATA_W-1:0] reg_data,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] b_out
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign reg_idx = sel[IDX_W-1:0];
    assign imm_ext = {{EXT_W{sel[IMM_W-1]}}, sel[IMM_W-1:0]};
    assign b_out   = sel[IMM_W] ? imm_ext : reg_data;
endmodule

// File: rtl/bfalu_field.sv
module bfalu_field #(
    parameter int DATA_W  = bfalu_pkg::DATA_W,
    parameter int LEN_W   = bfalu_pkg::LEN_W,
    parameter int FLD_SRC = bfalu_pkg::FLD_SRC
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] ins_out,
    output logic [DATA_W-1:0] uext_out,
    output logic [DATA_W-1:0] sext_out
);
    localparam int SH_W    = $clog2(DATA_W);
    localparam int LEN_TOP = SH_W + LEN_W - 1;

    logic [SH_W-1:0]   pos;
    logic [LEN_W-1:0]  len_code;
    logic [LEN_W:0]    len;
    logic [LEN_W:0]    len_m1;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] ins_mask;
    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] shifted;
    logic              top_bit;

    assign pos      = b[SH_W-1:0];
    assign len_code = b[LEN_TOP:SH_W];
    // zero width code is the widest field
    assign len      = (len_code == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_code};
    assign len_m1   = len - 1'b1;
    assign low_mask = ~({DATA_W{1'b1}} << len);

    assign ins_mask = low_mask << pos;
    assign payload  = (b >> FLD_SRC) << pos;
    assign ins_out  = (a & ~ins_mask) | (payload & ins_mask);

    assign shifted  = a >> pos;
    assign top_bit  = shifted[len_m1[SH_W-1:0]];
    assign uext_out = shifted & low_mask;
    assign sext_out = uext_out | (top_bit ? ~low_mask : '0);
endmodule

// File: rtl/bfalu_flip.sv
module bfalu_flip #(
    parameter int DATA_W = bfalu_pkg::DATA_W
) (
    input  logic [DATA_W-1:0]          a,
    input  logic [$clog2(DATA_W)-1:0]  stage_en,
    output logic [DATA_W-1:0]          y
);
    localparam int STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] stage_v [STAGES+1];

    assign stage_v[0] = a;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int GRP = 1 << s;
        logic [DATA_W-1:0] swapped;
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign swapped[i] = stage_v[s][i ^ GRP];
        end
        assign stage_v[s+1] = stage_en[s] ? swapped : stage_v[s];
    end

    assign y = stage_v[STAGES];
endmodule

// File: rtl/bfalu_core.sv
module bfalu_core
    import bfalu_pkg::*;
#(
    parameter int DW   = bfalu_pkg::DATA_W,
    parameter int IW   = bfalu_pkg::IMM_W,
    parameter int XW   = bfalu_pkg::IDX_W
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a_val,
    input  logic [IW:0]   b_sel,
    input  logic [DW-1:0] b_reg_data,
    output logic [XW-1:0] b_reg_idx,
    output logic [DW-1:0] result,
    output logic          illegal
);
    localparam int SH_W = $clog2(DW);

    alu_op_e           op_e;
    logic [DW-1:0]     opb;
    logic [SH_W-1:0]   amt;
    logic [2*DW-1:0]   ror_dbl;
    logic [DW-1:0]     fld_ins;
    logic [DW-1:0]     fld_u;
    logic [DW-1:0]     fld_s;
    logic [DW-1:0]     flip_y;

    assign op_e = alu_op_e'(op);
    assign amt  = opb[SH_W-1:0];

    bfalu_opb_sel #(.DATA_W(DW), .IMM_W(IW), .IDX_W(XW)) u_opb (
        .sel      (b_sel),
        .reg_data (b_reg_data),
        .reg_idx  (b_reg_idx),
        .b_out    (opb)
    );

    bfalu_field #(.DATA_W(DW)) u_field (
        .a        (a_val),
        .b        (opb),
        .ins_out  (fld_ins),
        .uext_out (fld_u),
        .sext_out (fld_s)
    );

    bfalu_flip #(.DATA_W(DW)) u_flip (
        .a        (a_val),
        .stage_en (amt),
        .y        (flip_y)
    );

    assign ror_dbl = {a_val, a_val} >> amt;

    always_comb begin
        illegal = 1'b0;
        result  = '0;
        unique case (op_e)
            OP_ADD:  result = a_val + opb;
            OP_ROR:  result = ror_dbl[DW-1:0];
            OP_SUB:  result = a_val - opb;
            OP_CAT:  result = (a_val << CAT_SH) | {{(DW-CAT_SH){1'b0}}, opb[CAT_SH-1:0]};
            OP_AND:  result = a_val & opb;
            OP_OR:   result = a_val | opb;
            OP_XOR:  result = a_val ^ opb;
            OP_XNOR: result = ~(a_val ^ opb);
            OP_SHL:  result = a_val << amt;
            OP_SHR:  result = a_val >> amt;
            OP_SAR:  result = DW'($signed(a_val) >>> amt);
            OP_FINS: result = fld_ins;
            OP_SEXT: result = fld_s;
            OP_UEXT: result = fld_u;
            OP_FLIP: result = flip_y;
            OP_BAD:  illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bfalu_checker.sv
module bfalu_checker #(
    parameter int DW = 32,
    parameter int IW = 10,
    parameter int XW = 5
) (
    input logic [3:0]    op,
    input logic [DW-1:0] a_val,
    input logic [IW:0]   b_sel,
    input logic [DW-1:0] b_reg_data,
    input logic [XW-1:0] b_reg_idx,
    input logic [DW-1:0] result,
    input logic          illegal
);
    logic [4:0] b_low;
    assign b_low = b_sel[IW] ? b_sel[4:0] : b_reg_data[4:0];

    always_comb begin
        // R11: flag only for the unused code
        p_illegal_code_r11: assert (illegal == (op == 4'hF))
            else $error("illegal flag mismatch");
        // R11: unused code gives zero
        p_illegal_zero_r11: assert (!illegal || result == '0)
            else $error("illegal result not zero");
        // R4: rotation by zero leaves A intact
        p_ror_zero_r4: assert (!(op == 4'h1 && b_low == 5'd0) || result == a_val)
            else $error("rotate by zero changed A");
        // R10: no flip stage enabled
        p_flip_idle_r10: assert (!(op == 4'hE && b_low == 5'd0) || result == a_val)
            else $error("idle flip changed A");
        // R3: AND cannot set a bit clear in A
        p_and_subset_r3: assert (!(op == 4'h4) || (result & ~a_val) == '0)
            else $error("AND set bit outside A");
        // R8: unsigned field never wider than 16 bits
        p_uext_width_r8: assert (!(op == 4'hD) || result[DW-1:16] == '0)
            else $error("unsigned extract too wide");
    end
endmodule

bind bfalu_core bfalu_checker #(.DW(DW), .IW(IW), .XW(XW)) u_bfalu_chk (
    .op         (op),
    .a_val      (a_val),
    .b_sel      (b_sel),
    .b_reg_data (b_reg_data),
    .b_reg_idx  (b_reg_idx),
    .result     (result),
    .illegal    (illegal)
);

// File: tb/bfalu_core_bench.sv
module bfalu_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'h0;
    logic [31:0] a_val = '0;
    logic [10:0] b_sel = '0;
    logic [31:0] b_reg_data = '0;
    logic [4:0]  b_reg_idx;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bfalu_core u_bfalu_core (
        .op(op), .a_val(a_val), .b_sel(b_sel), .b_reg_data(b_reg_data),
        .b_reg_idx(b_reg_idx), .result(result), .illegal(illegal)
    );

    function automatic logic [31:0] m_opb(input logic [10:0] s, input logic [31:0] r);
        logic [31:0] v;
        if (s[10]) begin
            v = {22'd0, s[9:0]};
            if (s[9]) v = v - 32'd1024;
        end else v = r;
        return v;
    endfunction

    function automatic int m_len(input logic [31:0] b);
        int l = int'(b[8:5]);
        return (l == 0) ? 16 : l;
    endfunction

    function automatic logic [31:0] m_extract(input logic [31:0] a, input logic [31:0] b, input bit sgn);
        logic [31:0] r = '0;
        int p = int'(b[4:0]);
        int l = m_len(b);
        for (int k = 0; k < l; k++) r[k] = (p + k < 32) ? a[p+k] : 1'b0;
        if (sgn) for (int k = l; k < 32; k++) r[k] = r[l-1];
        return r;
    endfunction

    function automatic logic [31:0] m_insert(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = a;
        int p = int'(b[4:0]);
        int l = m_len(b);
        for (int k = 0; k < l; k++) if (p + k < 32) r[p+k] = b[10+k];
        return r;
    endfunction

    function automatic logic [31:0] m_flip(input logic [31:0] a, input logic [4:0] en);
        logic [31:0] x = a;
        for (int s = 0; s < 5; s++) begin
            if (en[s]) begin
                int g = 1 << s;
                logic [31:0] m = '0;
                for (int i = 0; i < 32; i++) m[i] = ((i / g) % 2) == 0;
                x = ((x & m) << g) | ((x & ~m) >> g);
            end
        end
        return x;
    endfunction

    function automatic logic [31:0] m_alu(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        int n = int'(b[4:0]);
        logic [31:0] r = '0;
        case (o)
            4'h0: r = a + b;
            4'h1: for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
            4'h2: r = a - b;
            4'h3: r = {a[21:0], b[9:0]};
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = a ^ b;
            4'h7: r = ~(a ^ b);
            4'h8: for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
            4'h9: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
            4'hA: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
            4'hB: r = m_insert(a, b);
            4'hC: r = m_extract(a, b, 1'b1);
            4'hD: r = m_extract(a, b, 1'b0);
            4'hE: r = m_flip(a, b[4:0]);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [10:0] s, input logic [31:0] r);
        @(posedge clk);
        op = o; a_val = a; b_sel = s; b_reg_data = r;
        @(negedge clk);
    endtask

    task automatic run_model(input string req, input logic [3:0] o, input logic [31:0] a,
                             input logic [10:0] s, input logic [31:0] r);
        apply(o, a, s, r);
        check(req, result, m_alu(o, a, m_opb(s, r)));
        check(req, {31'd0, illegal}, {31'd0, o == 4'hF});
    endtask

    task automatic t_reset_state;
        apply(4'h0, '0, '0, '0);
        check("R2 idle", result, 32'd0);
        check("R11 idle", {31'd0, illegal}, 32'd0);
    endtask

    task automatic t_opb_r1;
        apply(4'h0, 32'd5, 11'h7FF, 32'hDEAD0000);
        check("R1 neg imm", result, 32'd4);
        apply(4'h0, 32'd5, 11'h5FF, 32'hDEAD0000);
        check("R1 pos imm", result, 32'd516);
        apply(4'h0, 32'd5, 11'h013, 32'h00000100);
        check("R1 reg data", result, 32'h105);
        check("R1 reg idx", {27'd0, b_reg_idx}, 32'd19);
    endtask

    task automatic t_arith_r2;
        apply(4'h0, 32'hFFFFFFFF, 11'h401, '0);
        check("R2 add wrap", result, 32'd0);
        apply(4'h2, 32'd3, 11'h000, 32'd5);
        check("R2 sub", result, 32'hFFFFFFFE);
    endtask

    task automatic t_logic_r3;
        apply(4'h4, 32'hF0F0_1234, 11'h0, 32'hFF00_FF00); check("R3 and", result, 32'hF000_1200);
        apply(4'h5, 32'hF0F0_1234, 11'h0, 32'hFF00_FF00); check("R3 or", result, 32'hFFF0_FF34);
        apply(4'h6, 32'hF0F0_1234, 11'h0, 32'hFF00_FF00); check("R3 xor", result, 32'h0FF0_ED34);
        apply(4'h7, 32'hF0F0_1234, 11'h0, 32'hFF00_FF00); check("R3 xnor", result, 32'hF00F_12CB);
    endtask

    task automatic t_rotate_r4;
        apply(4'h1, 32'h1234_5678, 11'h0, 32'hFFFF_FFE4); check("R4 ror 4", result, 32'h8123_4567);
        apply(4'h1, 32'h1234_5678, 11'h0, 32'h0000_0020); check("R4 ror high bits", result, 32'h1234_5678);
    endtask

    task automatic t_cat_r5;
        apply(4'h3, 32'hFFC0_0001, 11'h7FF, '0); check("R5 cat", result, 32'h0000_07FF);
    endtask

    task automatic t_shift_r6;
        apply(4'h8, 32'h8000_0001, 11'h0, 32'h23); check("R6 shl", result, 32'h0000_0008);
        apply(4'h9, 32'h8000_0001, 11'h0, 32'h23); check("R6 shr", result, 32'h1000_0000);
        apply(4'hA, 32'h8000_0001, 11'h0, 32'h23); check("R6 sar", result, 32'hF000_0000);
    endtask

    task automatic t_insert_r7;
        // pos 4, len 8, payload 0xAB
        apply(4'hB, 32'hFFFF_FFFF, 11'h0, (32'hAB << 10) | (32'd8 << 5) | 32'd4);
        check("R7 insert", result, 32'hFFFF_FABF);
        // len code 0 -> 16 bits at pos 0
        apply(4'hB, 32'hFFFF_FFFF, 11'h0, (32'h1234 << 10));
        check("R7 len16", result, 32'hFFFF_1234);
        // pos 28, len 8: upper four bits dropped
        apply(4'hB, 32'h0000_0000, 11'h0, (32'hA5 << 10) | (32'd8 << 5) | 32'd28);
        check("R7 overflow", result, 32'h5000_0000);
    endtask

    task automatic t_extract_r8_r9;
        apply(4'hD, 32'h0000_0F00, 11'h0, (32'd4 << 5) | 32'd8); check("R8 uext", result, 32'h0000_000F);
        apply(4'hC, 32'h0000_0F00, 11'h0, (32'd4 << 5) | 32'd8); check("R9 sext", result, 32'hFFFF_FFFF);
        apply(4'hC, 32'h0000_0700, 11'h0, (32'd4 << 5) | 32'd8); check("R9 sext pos", result, 32'h0000_0007);
        apply(4'hD, 32'h89AB_CDEF, 11'h0, 32'd8); check("R8 len16", result, 32'h0000_ABCD);
        apply(4'hC, 32'h89AB_CDEF, 11'h0, 32'd8); check("R9 len16", result, 32'hFFFF_ABCD);
    endtask

    task automatic t_flip_r10;
        apply(4'hE, 32'h0000_0001, 11'h41F, '0); check("R10 reverse", result, 32'h8000_0000);
        apply(4'hE, 32'h1234_5678, 11'h410, '0); check("R10 halves", result, 32'h5678_1234);
        apply(4'hE, 32'h1234_5678, 11'h000, 32'h20); check("R10 none", result, 32'h1234_5678);
    endtask

    task automatic t_illegal_r11;
        apply(4'hF, 32'hFFFF_FFFF, 11'h7FF, 32'hFFFF_FFFF);
        check("R11 result", result, 32'd0);
        check("R11 flag", {31'd0, illegal}, 32'd1);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] o = 4'(i % 16);
            run_model("R2-sweep R7 R10", o, $urandom, 11'($urandom), $urandom);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_opb_r1();
        t_arith_r2();
        t_logic_r3();
        t_rotate_r4();
        t_cat_r5();
        t_shift_r6();
        t_insert_r7();
        t_extract_r8_r9();
        t_flip_r10();
        t_illegal_r11();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule